// File: doc/BRIEF.md
# Wake-up event status controller

This block records power-management wake-up events for a network controller and turns enabled events into a power-management event status output. Three event sources arrive as single-cycle pulses: a magic packet was seen, a wake-up frame was matched, and the link state changed. Each pulse sets a sticky status bit that software reads through one register and clears with write-one-to-clear. Two enable bits in the same register decide whether magic-packet and link-change events raise the event status output. Wake-up frame events raise it unconditionally, because their enable is applied upstream.

There are two resets, both synchronous and active low. The power-up reset clears everything. The combined hardware/software reset reloads only the enable bits. The status bits and the event status output survive it, so software can still find out what woke the system after the host has reset the controller. The magic-packet enable reloads from two configuration straps. The event status output is cleared by its own strobe.

Top module: `wake_evt_ctrl`

## Requirements
- R1: An event pulse sets its status bit one clock later: wake-up frame at read bit 2, magic packet at bit 1, link change at bit 0.
- R2: A register write with a 1 in status bit 2, 1 or 0 clears that bit on the next clock. A 0 in that position leaves the bit unchanged.
- R3: When an event pulse and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R4: Power-up reset clears all status bits and the event status output. The hardware/software reset leaves both unchanged.
- R5: Either reset loads the link-change enable (bit 8) with 0. It loads the magic-packet enable (bit 9) with the AND of the power-management and wake-on-LAN straps. Outside reset, a register write loads bits 9 and 8 from the write data.
- R6: The event status output rises one clock after a magic-packet pulse while bit 9 is 1, after a link-change pulse while bit 8 is 1, or after any wake-up frame pulse. A magic-packet or link-change pulse whose enable is 0 does not raise it.
- R7: The event status output stays high until the clear strobe is pulsed. If a raising event and the strobe occur in the same cycle, the output stays high.
- R8: Read bits 7 to 3 and all bits above 9 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, synchronous, active low |
| sys_rst_n | input | 1 | Combined hardware/software reset, synchronous, active low |
| strap_pm_en | input | 1 | Power-management configuration strap |
| strap_wol_en | input | 1 | Wake-on-LAN configuration strap |
| ev_frame | input | 1 | Wake-up frame received pulse |
| ev_magic | input | 1 | Magic packet received pulse |
| ev_link | input | 1 | Link status changed pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, combinational from state |
| pme_clr | input | 1 | Clear strobe for the event status output |
| pme_status | output | 1 | Power-management event status, sticky |

## Verification
The checker watches several rules on every cycle. An event pulse sets its status bit. A clearing write or a zero write acts on a status bit as specified, and a simultaneous event beats the clear. The hardware/software reset leaves the status bits alone and reloads the enables from the straps. An enabled event raises the event status output, which then holds until its strobe, and the reserved bits stay zero. Some behaviour shows only over a scenario, and the bench checks it: a disabled event leaves the output low, and power-up reset with different strap settings changes the enable default. The bench also checks that writing ones to reserved bits is ignored and follows a whole set/clear/re-enable history.

// File: rtl/wake_evt_pkg.sv
package wake_evt_pkg;
   localparam int unsigned NUM_EV       = 3;
   localparam int unsigned POS_LINK     = 0;
   localparam int unsigned POS_MAGIC    = 1;
   localparam int unsigned POS_FRAME    = 2;
   localparam int unsigned POS_EN_LINK  = 8;
   localparam int unsigned POS_EN_MAGIC = 9;
   localparam int unsigned MIN_REG_W    = POS_EN_MAGIC + 1;
endpackage

// File: rtl/wake_sticky_bit.sv
module wake_sticky_bit (
   input  logic clk,
   input  logic por_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!por_n)      q_o <= 1'b0;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end
endmodule

// File: rtl/wake_status_bank.sv
module wake_status_bank #(
   parameter int unsigned NUM = 3
) (
   input  logic           clk,
   input  logic           por_n,
   input  logic [NUM-1:0] ev_i,
   input  logic [NUM-1:0] clr_i,
   output logic [NUM-1:0] q_o
);
   generate
      if (NUM < 1) begin : g_bad_num
         $error("wake_status_bank: NUM must be at least 1");
      end
      for (genvar i = 0; i < NUM; i++) begin : g_bit
         wake_sticky_bit u_bit (
            .clk   (clk),
            .por_n (por_n),
            .set_i (ev_i[i]),
            .clr_i (clr_i[i]),
            .q_o   (q_o[i])
         );
      end
   endgenerate
endmodule

// File: rtl/wake_enable_reg.sv
module wake_enable_reg (
   input  logic clk,
   input  logic por_n,
   input  logic sys_rst_n,
   input  logic strap_pm_en,
   input  logic strap_wol_en,
   input  logic wr_i,
   input  logic wr_magic_i,
   input  logic wr_link_i,
   output logic en_magic_o,
   output logic en_link_o
);
   logic any_rst;
   logic magic_dflt;

   assign any_rst    = !por_n || !sys_rst_n;
   assign magic_dflt = strap_pm_en && strap_wol_en;

   always_ff @(posedge clk) begin
      if (any_rst) begin
         en_magic_o <= magic_dflt;
         en_link_o  <= 1'b0;
      end else if (wr_i) begin
         en_magic_o <= wr_magic_i;
         en_link_o  <= wr_link_i;
      end
   end
endmodule

// File: rtl/wake_pme_gen.sv
module wake_pme_gen #(
   parameter int unsigned NUM = 3
) (
   input  logic           clk,
   input  logic           por_n,
   input  logic [NUM-1:0] ev_i,
   input  logic [NUM-1:0] mask_i,
   input  logic           clr_i,
   output logic           pme_o
);
   logic hit;
   assign hit = |(ev_i & mask_i);

   always_ff @(posedge clk) begin
      if (!por_n)      pme_o <= 1'b0;
      else if (hit)    pme_o <= 1'b1;
      else if (clr_i)  pme_o <= 1'b0;
   end
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
   import wake_evt_pkg::*;
#(
   parameter int unsigned REG_W = 16
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             sys_rst_n,
   input  logic             strap_pm_en,
   input  logic             strap_wol_en,
   input  logic             ev_frame,
   input  logic             ev_magic,
   input  logic             ev_link,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             pme_clr,
   output logic             pme_status
);
   logic [NUM_EV-1:0] ev_vec;
   logic [NUM_EV-1:0] clr_vec;
   logic [NUM_EV-1:0] status;
   logic [NUM_EV-1:0] pme_mask;
   logic              en_magic;
   logic              en_link;
   logic              unused_wdata_bits;

   generate
      if (REG_W < MIN_REG_W) begin : g_bad_width
         $error("wake_evt_ctrl: REG_W too narrow for the enable bits");
      end
   endgenerate

   assign ev_vec[POS_LINK]  = ev_link;
   assign ev_vec[POS_MAGIC] = ev_magic;
   assign ev_vec[POS_FRAME] = ev_frame;

   generate
      for (genvar i = 0; i < NUM_EV; i++) begin : g_clr
         assign clr_vec[i] = reg_wr && reg_wdata[i];
      end
   endgenerate

   wake_status_bank #(.NUM(NUM_EV)) u_status (
      .clk   (clk),
      .por_n (por_n),
      .ev_i  (ev_vec),
      .clr_i (clr_vec),
      .q_o   (status)
   );

   wake_enable_reg u_enable (
      .clk          (clk),
      .por_n        (por_n),
      .sys_rst_n    (sys_rst_n),
      .strap_pm_en  (strap_pm_en),
      .strap_wol_en (strap_wol_en),
      .wr_i         (reg_wr),
      .wr_magic_i   (reg_wdata[POS_EN_MAGIC]),
      .wr_link_i    (reg_wdata[POS_EN_LINK]),
      .en_magic_o   (en_magic),
      .en_link_o    (en_link)
   );

   assign pme_mask[POS_LINK]  = en_link;
   assign pme_mask[POS_MAGIC] = en_magic;
   assign pme_mask[POS_FRAME] = 1'b1;

   wake_pme_gen #(.NUM(NUM_EV)) u_pme (
      .clk    (clk),
      .por_n  (por_n),
      .ev_i   (ev_vec),
      .mask_i (pme_mask),
      .clr_i  (pme_clr),
      .pme_o  (pme_status)
   );

   always_comb begin
      reg_rdata                 = '0;
      reg_rdata[NUM_EV-1:0]     = status;
      reg_rdata[POS_EN_LINK]    = en_link;
      reg_rdata[POS_EN_MAGIC]   = en_magic;
   end

   assign unused_wdata_bits = ^reg_wdata;
endmodule

// File: rtl/wake_evt_chk.sv
module wake_evt_chk #(
   parameter int unsigned REG_W = 16
) (
   input logic             clk,
   input logic             por_n,
   input logic             sys_rst_n,
   input logic             strap_pm_en,
   input logic             strap_wol_en,
   input logic             ev_frame,
   input logic             ev_magic,
   input logic             ev_link,
   input logic             reg_wr,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic             pme_clr,
   input logic             pme_status
);
   logic no_ev;
   assign no_ev = !ev_frame && !ev_magic && !ev_link;

   p_set_r1: assert property (@(posedge clk) disable iff (!por_n)
      ev_magic |=> reg_rdata[1]);

   p_w1c_r2: assert property (@(posedge clk) disable iff (!por_n)
      (reg_wr && reg_wdata[0] && !ev_link) |=> !reg_rdata[0]);

   p_w0_keep_r2: assert property (@(posedge clk) disable iff (!por_n)
      (reg_wr && !reg_wdata[2] && !ev_frame) |=> reg_rdata[2] == $past(reg_rdata[2]));

   p_set_wins_r3: assert property (@(posedge clk) disable iff (!por_n)
      (reg_wr && reg_wdata[2] && ev_frame) |=> reg_rdata[2]);

   p_sysrst_keep_r4: assert property (@(posedge clk) disable iff (!por_n)
      (!sys_rst_n && !reg_wr && no_ev && !pme_clr) |=>
         ($stable(reg_rdata[2:0]) && $stable(pme_status)));

   p_en_dflt_r5: assert property (@(posedge clk) disable iff (!por_n)
      !sys_rst_n |=> (!reg_rdata[8] && reg_rdata[9] == $past(strap_pm_en && strap_wol_en)));

   p_pme_raise_r6: assert property (@(posedge clk) disable iff (!por_n)
      (ev_frame || (ev_magic && reg_rdata[9]) || (ev_link && reg_rdata[8])) |=> pme_status);

   p_pme_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
      (pme_status && !pme_clr) |=> pme_status);

   p_reserved_r8: assert property (@(posedge clk) disable iff (!por_n)
      (reg_rdata[7:3] == 5'd0) && ((reg_rdata >> 10) == '0));
endmodule

bind wake_evt_ctrl wake_evt_chk #(.REG_W(REG_W)) u_chk (
   .clk          (clk),
   .por_n        (por_n),
   .sys_rst_n    (sys_rst_n),
   .strap_pm_en  (strap_pm_en),
   .strap_wol_en (strap_wol_en),
   .ev_frame     (ev_frame),
   .ev_magic     (ev_magic),
   .ev_link      (ev_link),
   .reg_wr       (reg_wr),
   .reg_wdata    (reg_wdata),
   .reg_rdata    (reg_rdata),
   .pme_clr      (pme_clr),
   .pme_status   (pme_status)
);

// File: tb/wake_evt_ctrl_bench.sv
module wake_evt_ctrl_bench;
   localparam int unsigned REG_W = 16;
   localparam int NV = 12;

   logic             clk = 1'b0;
   logic             por_n = 1'b0;
   logic             sys_rst_n = 1'b0;
   logic             strap_pm_en = 1'b1;
   logic             strap_wol_en = 1'b1;
   logic             ev_frame = 1'b0;
   logic             ev_magic = 1'b0;
   logic             ev_link = 1'b0;
   logic             reg_wr = 1'b0;
   logic [REG_W-1:0] reg_wdata = '0;
   logic [REG_W-1:0] reg_rdata;
   logic             pme_clr = 1'b0;
   logic             pme_status;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wake_evt_ctrl #(.REG_W(REG_W)) u_wake_evt_ctrl (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
      .strap_pm_en(strap_pm_en), .strap_wol_en(strap_wol_en),
      .ev_frame(ev_frame), .ev_magic(ev_magic), .ev_link(ev_link),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pme_clr(pme_clr), .pme_status(pme_status)
   );

   // fields: frame, magic, link, wr, wdata[15:0], pme_clr, exp_rdata[15:0], exp_pme
   localparam logic [37:0] VEC [NV] = '{
      {1'b0,1'b0,1'b1,1'b0,16'h0000,1'b0,16'h0201,1'b0}, // R1 link sets, disabled: R6
      {1'b0,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0203,1'b1}, // R6 magic enabled
      {1'b0,1'b0,1'b0,1'b1,16'h0201,1'b0,16'h0202,1'b1}, // R2 clear bit0 only
      {1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,16'h0202,1'b0}, // R7 strobe clears
      {1'b0,1'b0,1'b0,1'b1,16'h0300,1'b0,16'h0302,1'b0}, // R5 write enables
      {1'b0,1'b0,1'b1,1'b0,16'h0000,1'b0,16'h0303,1'b1}, // R6 link enabled
      {1'b1,1'b0,1'b0,1'b0,16'h0000,1'b1,16'h0307,1'b1}, // R7 set beats strobe
      {1'b0,1'b1,1'b0,1'b1,16'h0007,1'b0,16'h0002,1'b1}, // R3 set beats W1C
      {1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,16'h0002,1'b0}, // R7 clear again
      {1'b0,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0002,1'b0}, // R6 magic disabled
      {1'b1,1'b0,1'b0,1'b0,16'h0000,1'b0,16'h0006,1'b1}, // R6 frame unconditional
      {1'b0,1'b0,1'b0,1'b1,16'hFCF8,1'b0,16'h0006,1'b1}  // R8 reserved ignored
   };
   localparam string VTAG [NV] = '{"R1","R6","R2","R7","R5","R6","R7","R3","R7","R6","R6","R8"};

   task automatic check(input string tag, input logic [REG_W-1:0] exp_rd, input logic exp_pme);
      n_chk++;
      if (reg_rdata !== exp_rd || pme_status !== exp_pme) begin
         n_fail++;
         $display("FAIL %s: rdata=%h pme=%b expected rdata=%h pme=%b",
                  tag, reg_rdata, pme_status, exp_rd, exp_pme);
      end
   endtask

   task automatic step(input logic f, input logic m, input logic l, input logic wr,
                       input logic [REG_W-1:0] wd, input logic pc);
      @(negedge clk);
      ev_frame = f; ev_magic = m; ev_link = l;
      reg_wr = wr; reg_wdata = wd; pme_clr = pc;
      @(posedge clk);
      #1;
      ev_frame = 1'b0; ev_magic = 1'b0; ev_link = 1'b0;
      reg_wr = 1'b0; reg_wdata = '0; pme_clr = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R4", 16'h0200, 1'b0); // reset state, straps 1/1 -> R5
      @(negedge clk);
      por_n = 1'b1; sys_rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][37], VEC[i][36], VEC[i][35], VEC[i][34], VEC[i][33:18], VEC[i][17]);
         check(VTAG[i], VEC[i][16:1], VEC[i][0]);
      end
      // enable link, then hw/sw reset with wol strap off
      step(1'b0, 1'b0, 1'b0, 1'b1, 16'h0100, 1'b0);
      check("R5", 16'h0106, 1'b1);
      @(negedge clk);
      strap_wol_en = 1'b0; sys_rst_n = 1'b0;
      @(posedge clk); #1;
      check("R4", 16'h0006, 1'b1);
      @(negedge clk);
      strap_wol_en = 1'b1;
      @(posedge clk); #1;
      check("R5", 16'h0206, 1'b1);
      @(negedge clk);
      sys_rst_n = 1'b1;
      // power-up reset clears status and pme
      @(negedge clk);
      por_n = 1'b0;
      @(posedge clk); #1;
      check("R4", 16'h0200, 1'b0);
      @(negedge clk);
      strap_pm_en = 1'b0;
      @(posedge clk); #1;
      check("R5", 16'h0000, 1'b0);
      @(negedge clk);
      por_n = 1'b1;
      step(1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0);
      check("R1", 16'h0001, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0);
      check("R2", 16'h0001, 1'b0);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule